// File: doc/BRIEF.md
# Spreading Code Toggle-Rate and Autocorrelation Qualifier

This block decides whether one period of a binary spreading code is fit for a low-power spread-spectrum link. It captures one period of chips from a stream and counts how often adjacent chips differ. A code with too many transitions is flagged as too costly in switching activity. The block then checks the stored period for a two-valued, impulse-shaped periodic autocorrelation, which is the signature of a maximum-length sequence.

A host starts a period by presenting the first chip with `period_start` high and the period length on `period_len`. The remaining chips follow on any cycles where `chip_valid` is high. After the last chip the block maps chip 0 to +1 and chip 1 to -1. It evaluates the correlation one lag at a time, spending one cycle per chip per lag. When every lag is done it raises `done` for one cycle. The results stay stable until the next period begins.

Top module: `chip_seq_qualifier`

## Requirements
- R1: After reset, `done`, `toggle_cnt`, `peak_corr`, `side_corr`, `impulse_ok` and `bad_lag` are all 0, and `toggle_ok` is 1.
- R2: When idle, a cycle with both `chip_valid` and `period_start` high takes that chip as chip 0 and samples `period_len` (legal range 2 to MAXN-1). Each later cycle with `chip_valid` high adds the next chip. Cycles with `chip_valid` low add nothing.
- R3: `toggle_cnt` equals the number of positions k in 1..N-1 where chip k differs from chip k-1. The step from the last chip back to the first is not counted.
- R4: `toggle_ok` is 1 exactly when 100·`toggle_cnt` ≤ 45·N, which means a toggle rate of at most 0.45.
- R5: With chip 0 taken as +1 and chip 1 as -1, `peak_corr` holds the lag-0 periodic correlation. This value equals N.
- R6: `impulse_ok` is 1 exactly when the periodic correlation is -1 at every lag 1..N-1. `side_corr` holds the correlation at the first lag that is not -1, or -1 when there is no such lag.
- R7: `bad_lag` holds the smallest nonzero lag whose correlation is not -1, or 0 when `impulse_ok` is 1.
- R8: `done` is a single-cycle pulse. It rises N·N clock edges after the edge that captures the last chip.
- R9: While a period is being captured, `period_start` and `period_len` are ignored. While correlations are being evaluated, all input activity is ignored. The reported results depend only on the N captured chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip | input | 1 | Chip value |
| chip_valid | input | 1 | Chip on `chip` is presented this cycle |
| period_start | input | 1 | Marks chip 0 of a period |
| period_len | input | LEN_W (10) | Period length N, sampled with chip 0 |
| toggle_cnt | output | LEN_W (10) | Adjacent-chip transitions in the period |
| toggle_ok | output | 1 | Toggle rate within the 0.45 limit |
| peak_corr | output | ACC_W (11) | Lag-0 correlation, signed |
| side_corr | output | ACC_W (11) | Off-peak correlation (first bad lag, else -1), signed |
| impulse_ok | output | 1 | All nonzero lags equal -1 |
| bad_lag | output | LEN_W (10) | First nonzero lag that is not -1, else 0 |
| done | output | 1 | One-cycle pulse when results are final |

## Verification
The hardest situation to reach is input traffic that arrives in the middle of a period or during the long correlation phase. This includes a second `period_start` mid-capture, a changed `period_len`, and a stream of valid chips while lags are being evaluated. None of that traffic may disturb the result. Randomised periods therefore insert gaps in `chip_valid` and raise `period_start` with random lengths on later chips. They also keep presenting random chips and start flags on every cycle of the correlation phase. Toggle-limit boundaries are also hard to hit by chance. They are reached with directed patterns of exactly 9 and 10 transitions at N = 20, where the limit falls on 9.

// File: rtl/chip_seq_qualifier.sv
module chip_seq_qualifier #(
  parameter int MAXN  = 512,
  parameter int LEN_W = $clog2(MAXN) + 1,
  parameter int ACC_W = LEN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chip,
  input  logic                    chip_valid,
  input  logic                    period_start,
  input  logic [LEN_W-1:0]        period_len,
  output logic [LEN_W-1:0]        toggle_cnt,
  output logic                    toggle_ok,
  output logic signed [ACC_W-1:0] peak_corr,
  output logic signed [ACC_W-1:0] side_corr,
  output logic                    impulse_ok,
  output logic [LEN_W-1:0]        bad_lag,
  output logic                    done
);
  localparam int AW     = $clog2(MAXN);
  localparam int PROD_W = LEN_W + 7;
  localparam logic signed [ACC_W-1:0] ONE    = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINUS1 = -ACC_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_CAP, S_COR} st_t;
  st_t st;

  logic                    chip_mem [MAXN];
  logic [LEN_W-1:0]        len_q, wr_idx, i_q, lag_q;
  logic                    prev_q;
  logic signed [ACC_W-1:0] acc_q;

  wire start_cap = (st == S_IDLE) && chip_valid && period_start;
  wire take_chip = (st == S_CAP) && chip_valid;
  wire [LEN_W-1:0] wr_ptr = start_cap ? '0 : wr_idx;

  wire [LEN_W:0]   sum_idx = {1'b0, i_q} + {1'b0, lag_q};
  wire [LEN_W-1:0] rd_idx  = (sum_idx >= {1'b0, len_q}) ? LEN_W'(sum_idx - {1'b0, len_q})
                                                         : sum_idx[LEN_W-1:0];
  wire same = chip_mem[i_q[AW-1:0]] == chip_mem[rd_idx[AW-1:0]];
  wire signed [ACC_W-1:0] acc_nxt = acc_q + (same ? ONE : MINUS1);
  wire last_term = (i_q == len_q - 1'b1);

  assign toggle_ok = (PROD_W'(toggle_cnt) * PROD_W'(100)) <= (PROD_W'(len_q) * PROD_W'(45));

  always_ff @(posedge clk)
    if (start_cap || take_chip) chip_mem[wr_ptr[AW-1:0]] <= chip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      len_q      <= '0;
      wr_idx     <= '0;
      i_q        <= '0;
      lag_q      <= '0;
      prev_q     <= 1'b0;
      acc_q      <= '0;
      toggle_cnt <= '0;
      peak_corr  <= '0;
      side_corr  <= '0;
      impulse_ok <= 1'b0;
      bad_lag    <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start_cap) begin
          prev_q     <= chip;
          len_q      <= period_len;
          wr_idx     <= LEN_W'(1);
          toggle_cnt <= '0;
          peak_corr  <= '0;
          side_corr  <= '0;
          impulse_ok <= 1'b1;
          bad_lag    <= '0;
          st         <= S_CAP;
        end
        S_CAP: if (take_chip) begin
          prev_q <= chip;
          if (chip != prev_q) toggle_cnt <= toggle_cnt + 1'b1;
          wr_idx <= wr_idx + 1'b1;
          if (wr_idx == len_q - 1'b1) begin
            st    <= S_COR;
            i_q   <= '0;
            lag_q <= '0;
            acc_q <= '0;
          end
        end
        S_COR: if (last_term) begin
          acc_q <= '0;
          i_q   <= '0;
          if (lag_q == '0) peak_corr <= acc_nxt;
          else if (impulse_ok) begin
            side_corr <= acc_nxt;
            if (acc_nxt != MINUS1) begin
              impulse_ok <= 1'b0;
              bad_lag    <= lag_q;
            end
          end
          if (lag_q == len_q - 1'b1) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else lag_q <= lag_q + 1'b1;
        end else begin
          acc_q <= acc_nxt;
          i_q   <= i_q + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_PEAK_IS_LEN: assert property (@(posedge clk) disable iff (!rst_n) done |-> peak_corr == $signed({1'b0, len_q})); // R5
  AST_TOGGLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) done |-> toggle_cnt < len_q); // R3
  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COR) |-> (acc_q <= $signed({1'b0, i_q})) && (acc_q >= -$signed({1'b0, i_q}))); // R5
  AST_SIDE_GOOD: assert property (@(posedge clk) disable iff (!rst_n) (done && impulse_ok) |-> (side_corr == MINUS1 && bad_lag == '0)); // R6
  AST_BADLAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !impulse_ok) |-> (bad_lag != '0 && bad_lag < len_q)); // R7
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n) (st != S_IDLE) |=> $stable(len_q)); // R9
endmodule

// File: tb/sim_chip_seq_qualifier.sv
module sim_chip_seq_qualifier;
  localparam int CLK_PERIOD = 10;
  localparam int MAXN = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chip = 1'b0, chip_valid = 1'b0, period_start = 1'b0;
  logic [9:0] period_len = '0;
  logic [9:0] toggle_cnt, bad_lag;
  logic toggle_ok, impulse_ok, done;
  logic signed [10:0] peak_corr, side_corr;

  int n_run = 0, n_fail = 0;
  bit pat [MAXN];

  always #(CLK_PERIOD/2) clk = ~clk;

  chip_seq_qualifier u0 (.clk(clk), .rst_n(rst_n), .chip(chip), .chip_valid(chip_valid),
    .period_start(period_start), .period_len(period_len), .toggle_cnt(toggle_cnt),
    .toggle_ok(toggle_ok), .peak_corr(peak_corr), .side_corr(side_corr),
    .impulse_ok(impulse_ok), .bad_lag(bad_lag), .done(done));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_tog(input int len);
    int t = 0;
    for (int k = 1; k < len; k++) if (pat[k] != pat[k-1]) t++;
    return t;
  endfunction

  function automatic int exp_corr(input int len, input int lag);
    int s = 0;
    for (int k = 0; k < len; k++) s += (pat[k] == pat[(k + lag) % len]) ? 1 : -1;
    return s;
  endfunction

  task automatic load_str(input string s);
    for (int k = 0; k < s.len(); k++) pat[k] = (s[k] == "1");
  endtask

  task automatic gen_lfsr(input int deg, input int tap);
    int s = 1;
    for (int k = 0; k < (1 << deg) - 1; k++) begin
      int fb;
      pat[k] = s[0];
      fb = (s ^ (s >> tap)) & 1;
      s = (s >> 1) | (fb << (deg - 1));
    end
  endtask

  task automatic run_period(input int len, input bit noise);
    int cyc, et, bl, sc, ok;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      while (noise && k > 0 && ($urandom % 4 == 0)) begin
        chip_valid = 1'b0; period_start = 1'b0; chip = $urandom;
        @(negedge clk);
      end
      chip_valid = 1'b1;
      chip = pat[k];
      period_start = (k == 0) || (noise && ($urandom % 2 == 1));
      period_len = (k == 0 || !noise) ? 10'(len) : 10'($urandom % 500 + 2);
    end
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (done || cyc > len * len + 20) break;
      if (noise) begin
        chip_valid = $urandom; chip = $urandom; period_start = $urandom;
        period_len = 10'($urandom);
      end else begin
        chip_valid = 1'b0; period_start = 1'b0;
      end
    end
    chip_valid = 1'b0; period_start = 1'b0;
    et = exp_tog(len);
    ok = 1; bl = 0; sc = -1;
    for (int g = 1; g < len; g++) begin
      int c = exp_corr(len, g);
      if (ok && c != -1) begin ok = 0; bl = g; sc = c; end
    end
    chk("R8 done latency", cyc, len * len + 1);
    chk("R3 toggle_cnt", int'(toggle_cnt), et);
    chk("R4 toggle_ok", int'(toggle_ok), (100 * et <= 45 * len) ? 1 : 0);
    chk("R5 peak_corr", int'(peak_corr), exp_corr(len, 0));
    chk("R6 impulse_ok", int'(impulse_ok), ok);
    chk("R6 side_corr", int'(side_corr), sc);
    chk("R7 bad_lag", int'(bad_lag), bl);
    if (noise) chk("R9 result unaffected by noise", int'(toggle_cnt), et);
    @(negedge clk);
    chk("R8 done single pulse", int'(done), 0);
    chk("R2 capture held after done", int'(toggle_cnt), et);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 toggle_cnt", int'(toggle_cnt), 0);
    chk("R1 toggle_ok", int'(toggle_ok), 1);
    chk("R1 peak_corr", int'(peak_corr), 0);
    chk("R1 side_corr", int'(side_corr), 0);
    chk("R1 impulse_ok", int'(impulse_ok), 0);
    chk("R1 bad_lag", int'(bad_lag), 0);

    // R2: valid-less cycles with a start flag must not begin a period
    period_start = 1'b1; period_len = 10'd7;
    repeat (3) @(negedge clk);
    period_start = 1'b0;
    chk("R2 no start without valid", int'(toggle_cnt), 0);

    load_str("1001110");                         run_period(7, 1'b0);
    load_str("011011110001000");                 run_period(15, 1'b0);
    chk("R3 fifteen-chip example count", exp_tog(15), 6);
    load_str("0010011110011111000110111011100"); run_period(31, 1'b0);
    load_str("0101010");                         run_period(7, 1'b0);
    for (int k = 0; k < 20; k++) pat[k] = (k < 10) ? k[0] : 1'b1;
    run_period(20, 1'b0);
    for (int k = 0; k < 20; k++) pat[k] = (k < 11) ? k[0] : 1'b0;
    run_period(20, 1'b0);
    for (int k = 0; k < 9; k++) pat[k] = 1'b0;
    run_period(9, 1'b0);
    gen_lfsr(4, 1); run_period(15, 1'b1);
    gen_lfsr(5, 2); run_period(31, 1'b1);
    gen_lfsr(6, 1); run_period(63, 1'b0);

    for (int r = 0; r < 20; r++) begin
      int len = $urandom % 38 + 3;
      for (int k = 0; k < len; k++) pat[k] = $urandom;
      run_period(len, r[0]);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule